// File: doc/BRIEF.md
# Trace Enable and Error Controller

This block decides whether a trace packet generator may emit anything at all. Software controls it with a trace-enable bit and an error-clear write. The packet output path reports operational problems on a set of error strobe lines. An overflow indication tells the block when packet output has been lost. From these inputs it produces a registered trigger-enable signal that gates every packet type, and a sticky error status bit that can only be cleared in a fixed software sequence.

During an overflow the block keeps a cycle counter running on a free-running tick. It requests no cycle packet while the overflow lasts. When the generator emits its overflow packet and cycle-accurate mode is on, the block raises a one-cycle request for a cycle-count packet. The request carries the number of ticks counted during the overflow, together with a flag that marks the value as doubtful when the counter wrapped. The block builds no packets and inspects no output memory. It only supplies these enable, error and timing controls.

Top module: `trace_gate_ctrl`

## Requirements
- R1: While reset is high, and after it is released, trig_en, err_sticky, cyc_pkt_req, cyc_wrap_flag and cyc_pkt_val are all 0.
- R2: trig_en is registered and equals sw_trace_en AND NOT ovf_active AND NOT (error after this cycle), one cycle after those inputs are sampled.
- R3: Any bit of op_err high while sw_trace_en is 1 sets err_sticky at the next clock edge, and trig_en is 0 at that same edge.
- R4: op_err strobes while sw_trace_en is 0 are ignored: err_sticky stays 0 and trig_en follows R2.
- R5: Once set, err_sticky stays 1 until an accepted clear, however sw_trace_en is toggled, and while it is 1, trig_en is 0.
- R6: A clear write (sw_err_clr=1) while sw_trace_en is 1 is ignored and err_sticky stays 1.
- R7: A clear write while sw_trace_en is 0 clears err_sticky at the next edge. trig_en returns to 1 one cycle after sw_trace_en is later set to 1.
- R8: ovf_active=1 forces trig_en to 0 one cycle later. cyc_pkt_req stays 0 for the whole overflow, while the cycle counter counts cyc_tick.
- R9: The counter restarts at the first cycle of an overflow, counting the tick of that cycle. When ovf_pkt_emit is 1 with cyc_acc_en=1, sw_trace_en=1 and no error, cyc_pkt_req pulses for one cycle at the next edge. The pulse carries in cyc_pkt_val the number of ticks seen in ovf_active cycles up to and including the emit cycle, modulo 2^CNT_W.
- R10: With cyc_acc_en=0, ovf_pkt_emit raises no cyc_pkt_req.
- R11: cyc_wrap_flag becomes 1 one cycle after a tick that takes the counter from all ones to zero during an overflow. It returns to 0 one cycle after the first cycle of the next overflow.
- R12: ovf_pkt_emit while err_sticky is set, or while an error is being latched, raises no cyc_pkt_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_trace_en | input | 1 | Software trace-enable bit |
| sw_err_clr | input | 1 | Software write strobe that clears the error bit |
| op_err | input | ERR_SRC | Operational error strobes from the output path |
| ovf_active | input | 1 | High while an overflow is in progress |
| ovf_pkt_emit | input | 1 | Strobe when the overflow packet is emitted |
| cyc_acc_en | input | 1 | Cycle-accurate mode enable |
| cyc_tick | input | 1 | Free-running cycle tick |
| trig_en | output | 1 | Registered gate for all packet generation |
| err_sticky | output | 1 | Sticky error status |
| cyc_pkt_req | output | 1 | One-cycle request for a cycle-count packet |
| cyc_pkt_val | output | CNT_W | Ticks counted during the overflow |
| cyc_wrap_flag | output | 1 | Counter wrapped during the overflow |

## Verification
The checker tests these properties on every cycle:
- the error always blocks the gate;
- the error is sticky;
- a clear is refused while tracing is enabled;
- strobes are ignored while tracing is disabled;
- overflow suppresses the gate;
- every request and every rise of the wrap flag has a legal cause.

Only the bench scenarios can show the exact tick count reported after an overflow, and the counter restart at each new overflow. They also show the modulo value after a wrap and the complete recovery order, with tracing resuming only after disable, clear and re-enable.

// File: rtl/trace_gate_pkg.sv
package trace_gate_pkg;
  localparam int DEF_ERR_SRC = 3;
  localparam int DEF_CNT_W   = 8;

  typedef struct packed {
    logic req;
    logic wrap;
  } cyc_flags_t;
endpackage

// File: rtl/trace_err_latch.sv
module trace_err_latch #(
  parameter int ERR_SRC = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trace_en,
  input  logic               clr_wr,
  input  logic [ERR_SRC-1:0] err_strobe,
  output logic               err_q,
  output logic               err_d
);
  logic any_err;
  logic clr_ok;

  generate
    if (ERR_SRC == 1) begin : g_single
      assign any_err = err_strobe[0];
    end else begin : g_multi
      assign any_err = |err_strobe;
    end
  endgenerate

  // a clear is honoured only once tracing has been turned off
  assign clr_ok = clr_wr & ~trace_en;

  always_comb begin
    if (err_q) err_d = ~clr_ok;
    else       err_d = trace_en & any_err;
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= err_d;
  end
endmodule

// File: rtl/trace_gate_reg.sv
module trace_gate_reg (
  input  logic clk,
  input  logic rst,
  input  logic trace_en,
  input  logic err_d,
  input  logic ovf_active,
  output logic trig_q
);
  always_ff @(posedge clk) begin
    if (rst) trig_q <= 1'b0;
    else     trig_q <= trace_en & ~err_d & ~ovf_active;
  end
endmodule

// File: rtl/ovf_cycle_tracker.sv
module ovf_cycle_tracker
  import trace_gate_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ovf_active,
  input  logic             cyc_tick,
  input  logic             emit,
  input  logic             acc_en,
  input  logic             allow,
  output cyc_flags_t       flags,
  output logic [CNT_W-1:0] val
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  logic             ovf_prev;
  logic             ovf_start;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap_q, wrap_d;
  logic             fire;

  assign ovf_start = ovf_active & ~ovf_prev;
  assign fire      = emit & acc_en & allow;

  always_comb begin
    cnt_d  = cnt_q;
    wrap_d = wrap_q;
    if (ovf_start) begin
      cnt_d  = cyc_tick ? ONE : '0;
      wrap_d = 1'b0;
    end else if (ovf_active && cyc_tick) begin
      cnt_d = cnt_q + ONE;
      if (cnt_q == FULL) wrap_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_prev   <= 1'b0;
      cnt_q      <= '0;
      wrap_q     <= 1'b0;
      flags.req  <= 1'b0;
      flags.wrap <= 1'b0;
      val        <= '0;
    end else begin
      ovf_prev   <= ovf_active;
      cnt_q      <= cnt_d;
      wrap_q     <= wrap_d;
      flags.req  <= fire;
      flags.wrap <= wrap_d;
      if (fire) val <= cnt_d;
    end
  end
endmodule

// File: rtl/trace_gate_ctrl.sv
module trace_gate_ctrl
  import trace_gate_pkg::*;
#(
  parameter int ERR_SRC = DEF_ERR_SRC,
  parameter int CNT_W   = DEF_CNT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sw_trace_en,
  input  logic               sw_err_clr,
  input  logic [ERR_SRC-1:0] op_err,
  input  logic               ovf_active,
  input  logic               ovf_pkt_emit,
  input  logic               cyc_acc_en,
  input  logic               cyc_tick,
  output logic               trig_en,
  output logic               err_sticky,
  output logic               cyc_pkt_req,
  output logic [CNT_W-1:0]   cyc_pkt_val,
  output logic               cyc_wrap_flag
);
  logic       err_d;
  cyc_flags_t flags;

  trace_err_latch #(.ERR_SRC(ERR_SRC)) u_err (
    .clk        (clk),
    .rst        (rst),
    .trace_en   (sw_trace_en),
    .clr_wr     (sw_err_clr),
    .err_strobe (op_err),
    .err_q      (err_sticky),
    .err_d      (err_d)
  );

  trace_gate_reg u_gate (
    .clk        (clk),
    .rst        (rst),
    .trace_en   (sw_trace_en),
    .err_d      (err_d),
    .ovf_active (ovf_active),
    .trig_q     (trig_en)
  );

  ovf_cycle_tracker #(.CNT_W(CNT_W)) u_cyc (
    .clk        (clk),
    .rst        (rst),
    .ovf_active (ovf_active),
    .cyc_tick   (cyc_tick),
    .emit       (ovf_pkt_emit),
    .acc_en     (cyc_acc_en),
    .allow      (sw_trace_en & ~err_d),
    .flags      (flags),
    .val        (cyc_pkt_val)
  );

  assign cyc_pkt_req   = flags.req;
  assign cyc_wrap_flag = flags.wrap;
endmodule

// File: rtl/trace_gate_checker.sv
module trace_gate_checker #(
  parameter int ERR_SRC = 3,
  parameter int CNT_W   = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               sw_trace_en,
  input logic               sw_err_clr,
  input logic [ERR_SRC-1:0] op_err,
  input logic               ovf_active,
  input logic               ovf_pkt_emit,
  input logic               cyc_acc_en,
  input logic               cyc_tick,
  input logic               trig_en,
  input logic               err_sticky,
  input logic               cyc_pkt_req,
  input logic [CNT_W-1:0]   cyc_pkt_val,
  input logic               cyc_wrap_flag
);
  assert_trig_needs_en_R2: assert property (@(posedge clk) disable iff (rst)
    trig_en |-> ($past(sw_trace_en) && !$past(ovf_active)));

  assert_err_blocks_trig_R3: assert property (@(posedge clk) disable iff (rst)
    err_sticky |-> !trig_en);

  assert_ignore_when_off_R4: assert property (@(posedge clk) disable iff (rst)
    (!sw_trace_en && !err_sticky) |=> !err_sticky);

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (err_sticky && !(sw_err_clr && !sw_trace_en)) |=> err_sticky);

  assert_clr_refused_R6: assert property (@(posedge clk) disable iff (rst)
    (err_sticky && sw_trace_en) |=> err_sticky);

  assert_ovf_gates_R8: assert property (@(posedge clk) disable iff (rst)
    ovf_active |=> !trig_en);

  assert_req_cause_R9: assert property (@(posedge clk) disable iff (rst)
    cyc_pkt_req |-> $past(ovf_pkt_emit && cyc_acc_en));

  assert_wrap_cause_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(cyc_wrap_flag) |-> $past(ovf_active && cyc_tick));
endmodule

bind trace_gate_ctrl trace_gate_checker #(.ERR_SRC(ERR_SRC), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/trace_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module trace_gate_ctrl_tb_top;
  localparam int ERR_SRC = 3;
  localparam int CNT_W   = 4;
  localparam int NVEC    = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw_trace_en = 1'b0, sw_err_clr = 1'b0;
  logic [ERR_SRC-1:0] op_err = '0;
  logic ovf_active = 1'b0, ovf_pkt_emit = 1'b0, cyc_acc_en = 1'b0, cyc_tick = 1'b0;
  logic trig_en, err_sticky, cyc_pkt_req, cyc_wrap_flag;
  logic [CNT_W-1:0] cyc_pkt_val;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  trace_gate_ctrl #(.ERR_SRC(ERR_SRC), .CNT_W(CNT_W)) dut_i (.*);

  // {en, err strobe, clr, ovf, expected trig, expected err}
  localparam logic [5:0] VEC [NVEC] = '{
    6'b1000_10,  // R2 enable
    6'b1001_00,  // R8 overflow gates
    6'b1000_10,  // R2 resume
    6'b0100_00,  // R4 strobe while off
    6'b1000_10,  // R4 no error left behind
    6'b1100_01,  // R3 error latched
    6'b1010_01,  // R6 clear refused
    6'b1000_01,  // R5 stays
    6'b0000_01,  // R5 stays when off
    6'b1000_01,  // R5 re-enable without clear
    6'b0010_00,  // R7 clear accepted
    6'b1000_10,  // R7 resume
    6'b0110_00,  // R4 strobe with clear while off
    6'b1101_01,  // R3 error during overflow
    6'b0010_00   // R7 clear
  };
  localparam int VTAG [NVEC] = '{2, 8, 2, 4, 4, 3, 6, 5, 5, 5, 7, 7, 4, 3, 7};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick_edge();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    sw_trace_en = 0; sw_err_clr = 0; op_err = '0;
    ovf_active = 0; ovf_pkt_emit = 0; cyc_acc_en = 0; cyc_tick = 0;
    repeat (2) tick_edge();
    rst = 1'b0;
  endtask

  // run an overflow of n cycles with ticks in the first k, then one emit cycle
  task automatic run_ovf(input int n, input int k, input bit acc);
    cyc_acc_en = acc;
    for (int i = 0; i < n; i++) begin
      ovf_active = 1'b1;
      cyc_tick = (i < k);
      tick_edge();
      chk(cyc_pkt_req == 1'b0, "R8 no req in ovf", cyc_pkt_req, 0);
    end
    ovf_active = 1'b0;
    cyc_tick = 1'b0;
    ovf_pkt_emit = 1'b1;
    tick_edge();
    ovf_pkt_emit = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    rst = 1'b1;
    sw_trace_en = 1'b1;
    repeat (2) tick_edge();
    chk({trig_en, err_sticky, cyc_pkt_req, cyc_wrap_flag} == 4'b0 && cyc_pkt_val == '0,
        "R1 in reset", {trig_en, err_sticky, cyc_pkt_req, cyc_wrap_flag}, 0);
    do_reset();
    tick_edge();
    chk({trig_en, err_sticky, cyc_pkt_req, cyc_wrap_flag} == 4'b0,
        "R1 after reset", {trig_en, err_sticky, cyc_pkt_req, cyc_wrap_flag}, 0);

    // gate and error sequence table
    for (int v = 0; v < NVEC; v++) begin
      sw_trace_en = VEC[v][5];
      op_err      = VEC[v][4] ? 3'b010 : 3'b000;
      sw_err_clr  = VEC[v][3];
      ovf_active  = VEC[v][2];
      tick_edge();
      chk(trig_en == VEC[v][1], $sformatf("R%0d trig vec %0d", VTAG[v], v), trig_en, VEC[v][1]);
      chk(err_sticky == VEC[v][0], $sformatf("R%0d err vec %0d", VTAG[v], v), err_sticky, VEC[v][0]);
    end
    op_err = '0; sw_err_clr = 0; ovf_active = 0;

    // R9 count of ticks during overflow
    do_reset();
    sw_trace_en = 1'b1;
    run_ovf(5, 3, 1'b1);
    chk(cyc_pkt_req == 1'b1, "R9 req", cyc_pkt_req, 1);
    chk(cyc_pkt_val == 4'd3, "R9 val", cyc_pkt_val, 3);
    chk(cyc_wrap_flag == 1'b0, "R11 no wrap", cyc_wrap_flag, 0);
    chk(trig_en == 1'b1, "R8 trig back", trig_en, 1);
    tick_edge();
    chk(cyc_pkt_req == 1'b0, "R9 single pulse", cyc_pkt_req, 0);

    // R9 counter restarts at a new overflow
    run_ovf(2, 2, 1'b1);
    chk(cyc_pkt_val == 4'd2, "R9 restart val", cyc_pkt_val, 2);

    // R10 mode off
    run_ovf(3, 3, 1'b0);
    chk(cyc_pkt_req == 1'b0, "R10 no req", cyc_pkt_req, 0);

    // R11 wrap during overflow: 18 ticks in a 4-bit counter
    run_ovf(18, 18, 1'b1);
    chk(cyc_pkt_req == 1'b1, "R11 req", cyc_pkt_req, 1);
    chk(cyc_pkt_val == 4'd2, "R11 modulo val", cyc_pkt_val, 2);
    chk(cyc_wrap_flag == 1'b1, "R11 wrap set", cyc_wrap_flag, 1);
    ovf_active = 1'b1;
    tick_edge();
    chk(cyc_wrap_flag == 1'b0, "R11 wrap cleared", cyc_wrap_flag, 0);
    ovf_active = 1'b0;
    tick_edge();

    // R12 error blocks the request
    op_err = 3'b001;
    tick_edge();
    op_err = '0;
    chk(err_sticky == 1'b1, "R12 err set", err_sticky, 1);
    run_ovf(3, 3, 1'b1);
    chk(cyc_pkt_req == 1'b0, "R12 no req", cyc_pkt_req, 0);

    // R12 error being latched in the emit cycle
    sw_trace_en = 0; sw_err_clr = 1; tick_edge();
    sw_err_clr = 0; sw_trace_en = 1; tick_edge();
    ovf_active = 1; cyc_tick = 1; tick_edge();
    ovf_active = 0; cyc_tick = 0; ovf_pkt_emit = 1; op_err = 3'b100; tick_edge();
    ovf_pkt_emit = 0; op_err = '0;
    chk(cyc_pkt_req == 1'b0, "R12 no req same cycle", cyc_pkt_req, 0);
    chk(err_sticky == 1'b1, "R3 latched at emit", err_sticky, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule